// File: doc/BRIEF.md
# Serial Audio Port, Clock-Slave Transmit and Receive

This block is a serial audio port that runs as a clock slave. An external device supplies the bit clock and the word clock, and the block follows them. On the transmit side, parallel left/right PCM pairs are pushed into a small sample FIFO. One pair is taken at the start of every frame and shifted out MSB first on the serial data line. On the receive side, the block captures the mono microphone stream into parallel words and produces one word per frame.

Two configuration fields shape each slot. The offset field sets how many bit-clock cycles pass between a word-clock edge and the first data bit. The width field sets how many bits of each sample are carried. It uses a non-linear code: 0 and every value from 16 up mean a full 16-bit sample.

The external clocks are brought into the system clock domain through a synchronizer chain. The block detects their edges there, so every part of the logic runs on the system clock. The synchronized bit clock must be at least four times slower than the system clock. The nominal rates are a 48 kHz or 24 kHz word rate with a bit clock of about 3.07 MHz.

Top module: `i2s_slave_port`

## Requirements
- R1: While reset is high and in the first cycle after it, `sdata_out` is 0, `rx_valid` is 0, `tx_underflow` is 0 and `tx_full` is 0.
- R2: Bit-clock cycles in a slot are numbered from 0, where cycle 0 is the cycle whose rising edge is the first to see the new word-clock level. Transmit data is sent MSB first. The first bit is present at the rising edge of cycle `cfg_offset`. `sdata_out` changes only after a falling bit-clock edge.
- R3: An offset field value of 0 behaves exactly like a value of 1, on both transmit and receive.
- R4: The width field values 1 to 15 carry that many bits per slot. The values 0 and 16 to 31 carry all 16 bits. Every transmit cycle of a slot outside the data window sends 0.
- R5: Data bits whose cycle would fall at or after the end of the slot are dropped. They never appear in the following slot. In particular, cycle 0 of every slot sends 0.
- R6: The left slot is the half-frame with the word clock low, and the right slot is the half with it high. With `cfg_stereo`=1 the right slot sends the pair's right sample. With `cfg_stereo`=0 it sends the left sample again.
- R7: A push is accepted only while `tx_full` is 0, and a push while full is dropped. `tx_full` is 1 when FIFO_DEPTH (default 4) pairs are held. Pairs are sent in push order, with one pair taken at the start of each left slot.
- R8: If the FIFO is empty at the start of a left slot, the block sends 0 in both slots of that frame and sets `tx_underflow`. The flag stays 1 until reset.
- R9: The receiver samples `sdata_in` on rising bit-clock edges inside the data window of the left slot and builds the word MSB first. Bit positions outside the window are 0, and right-slot data is ignored. The word appears on `rx_data` with a one-cycle `rx_valid` pulse soon after the right slot starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | External bit clock, asynchronous |
| wclk_in | input | 1 | External word clock, low for the left slot and high for the right slot |
| sdata_in | input | 1 | Serial microphone data |
| sdata_out | output | 1 | Serial playback data |
| cfg_offset | input | 5 | Bit-clock cycles from the word-clock edge to the first data bit (0 acts as 1) |
| cfg_width | input | 5 | Sample width code (0 and 16..31 mean 16 bits) |
| cfg_stereo | input | 1 | 1: separate right sample; 0: left sample in both slots |
| tx_push | input | 1 | Write one sample pair into the FIFO |
| tx_left | input | 16 | Left sample to push |
| tx_right | input | 16 | Right sample to push |
| tx_full | output | 1 | FIFO holds FIFO_DEPTH pairs |
| tx_underflow | output | 1 | Sticky flag: a frame started with the FIFO empty |
| rx_valid | output | 1 | One-cycle strobe for a new received word |
| rx_data | output | 16 | Received microphone word |

## Verification
The assertions assume the following about the inputs. The word clock and the serial input change only near falling bit-clock edges. Each bit-clock half period lasts several system cycles, long enough for the synchronizer, the edge detector and the output register to settle. The slot length stays the same from one slot to the next, because the transmitter uses the length it measured in the previous slot to avoid driving past the boundary. The bench acts as the external device. It changes its clock, word clock and data only on the falling system-clock edge, holds each bit-clock level for eight system cycles, and always sends 32-cycle slots. This keeps the stimulus inside those assumptions.

// File: rtl/i2s_pkg.sv
package i2s_pkg;
    localparam int SAMPLE_W = 16;
    localparam int CFG_W    = 5;
    localparam int CNT_W    = 7;
    localparam int IDX_W    = $clog2(SAMPLE_W);

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [CNT_W-1:0]    cnt_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } frame_t;

    // one bit-clock rising edge as seen in the system domain
    typedef struct packed {
        logic strobe;
        logic start;
        logic right;
        cnt_t idx;
        logic data;
    } bit_evt_t;

    function automatic cnt_t sat_inc(cnt_t v);
        return (v == '1) ? v : v + 1'b1;
    endfunction

    function automatic cnt_t eff_offset(logic [CFG_W-1:0] f);
        return (f == '0) ? cnt_t'(1) : cnt_t'(f);
    endfunction

    function automatic cnt_t eff_width(logic [CFG_W-1:0] f);
        if (f == '0 || cnt_t'(f) >= cnt_t'(SAMPLE_W))
            return cnt_t'(SAMPLE_W);
        return cnt_t'(f);
    endfunction

    function automatic logic in_window(cnt_t pos, cnt_t off, cnt_t wid);
        logic [CNT_W:0] lo, hi, p;
        p  = {1'b0, pos};
        lo = {1'b0, off};
        hi = lo + {1'b0, wid};
        return (p >= lo) && (p < hi);
    endfunction

    function automatic logic [IDX_W-1:0] bit_sel(cnt_t pos, cnt_t off);
        cnt_t d;
        d = pos - off;
        return IDX_W'(SAMPLE_W-1) - d[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/i2s_slot_timer.sv
module i2s_slot_timer
    import i2s_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bclk_in,
    input  logic     wclk_in,
    input  logic     sdata_in,
    output logic     wclk_s,
    output logic     bclk_fall,
    output bit_evt_t evt,
    output cnt_t     cnt,
    output cnt_t     slot_len
);
    localparam int N = 3;

    logic [STAGES-1:0][N-1:0] chain;
    logic bclk_s, sdin_s, bclk_q, rise;
    logic primed, ws_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= {sdata_in, wclk_in, bclk_in};
            for (int s = 1; s < STAGES; s++)
                chain[s] <= chain[s-1];
        end
    end

    assign {sdin_s, wclk_s, bclk_s} = chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) bclk_q <= 1'b0;
        else     bclk_q <= bclk_s;
    end

    assign rise      = bclk_s & ~bclk_q;
    assign bclk_fall = ~bclk_s & bclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            primed   <= 1'b0;
            ws_q     <= 1'b0;
            cnt      <= '1;
            slot_len <= '0;
            evt      <= '0;
        end else begin
            evt.strobe <= 1'b0;
            evt.start  <= 1'b0;
            if (rise) begin
                if (!primed) begin
                    primed <= 1'b1;
                    ws_q   <= wclk_s;
                end else if (wclk_s != ws_q) begin
                    ws_q       <= wclk_s;
                    slot_len   <= sat_inc(cnt);
                    cnt        <= '0;
                    evt.strobe <= 1'b1;
                    evt.start  <= 1'b1;
                    evt.right  <= wclk_s;
                    evt.idx    <= '0;
                    evt.data   <= sdin_s;
                end else begin
                    cnt        <= sat_inc(cnt);
                    evt.strobe <= 1'b1;
                    evt.right  <= ws_q;
                    evt.idx    <= sat_inc(cnt);
                    evt.data   <= sdin_s;
                end
            end
        end
    end
endmodule

// File: rtl/i2s_sample_fifo.sv
module i2s_sample_fifo
    import i2s_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  frame_t wr_data,
    input  logic   pop,
    output frame_t rd_data,
    output logic   full,
    output logic   empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    frame_t          mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count;
    logic            do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] wrap_inc(logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wrap_inc(wr_ptr);
            if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/i2s_tx_ser.sv
module i2s_tx_ser
    import i2s_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bclk_fall,
    input  bit_evt_t evt,
    input  cnt_t     cnt,
    input  cnt_t     slot_len,
    input  cnt_t     off,
    input  cnt_t     wid,
    input  logic     stereo,
    input  logic     fifo_empty,
    input  frame_t   fifo_rd,
    output logic     fifo_pop,
    output logic     sd_out,
    output logic     underflow
);
    frame_t          pair_q;
    sample_t         word_q;
    logic [CNT_W:0]  tgt;
    logic            tx_bit;

    assign fifo_pop = evt.start && !evt.right && !fifo_empty;

    // bit due at the rising edge that follows this falling edge
    always_comb begin
        tgt    = {1'b0, cnt} + 1'b1;
        tx_bit = 1'b0;
        if (tgt < {1'b0, slot_len} && in_window(tgt[CNT_W-1:0], off, wid))
            tx_bit = word_q[bit_sel(tgt[CNT_W-1:0], off)];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q    <= '0;
            word_q    <= '0;
            sd_out    <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (evt.start) begin
                if (!evt.right) begin
                    if (!fifo_empty) begin
                        pair_q <= fifo_rd;
                        word_q <= fifo_rd.left;
                    end else begin
                        pair_q    <= '0;
                        word_q    <= '0;
                        underflow <= 1'b1;
                    end
                end else begin
                    word_q <= stereo ? pair_q.right : pair_q.left;
                end
            end
            if (bclk_fall) sd_out <= tx_bit;
        end
    end
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
    import i2s_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bit_evt_t evt,
    input  cnt_t     off,
    input  cnt_t     wid,
    output logic     rx_valid,
    output sample_t  rx_data
);
    sample_t acc;
    logic    left_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            left_seen <= 1'b0;
            rx_valid  <= 1'b0;
            rx_data   <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (evt.strobe) begin
                if (evt.start && evt.right && left_seen) begin
                    rx_valid <= 1'b1;
                    rx_data  <= acc;
                end
                if (evt.start && !evt.right) begin
                    left_seen <= 1'b1;
                    acc       <= '0;
                end else if (!evt.right && in_window(evt.idx, off, wid)) begin
                    acc[bit_sel(evt.idx, off)] <= evt.data;
                end
            end
        end
    end
endmodule

// File: rtl/i2s_slave_port.sv
module i2s_slave_port
    import i2s_pkg::*;
#(
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_in,
    input  logic                wclk_in,
    input  logic                sdata_in,
    output logic                sdata_out,
    input  logic [CFG_W-1:0]    cfg_offset,
    input  logic [CFG_W-1:0]    cfg_width,
    input  logic                cfg_stereo,
    input  logic                tx_push,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                tx_full,
    output logic                tx_underflow,
    output logic                rx_valid,
    output logic [SAMPLE_W-1:0] rx_data
);
    logic     wclk_s, bclk_fall;
    bit_evt_t evt;
    cnt_t     cnt, slot_len, off_eff, wid_eff;
    frame_t   fifo_wr, fifo_rd;
    logic     fifo_pop, fifo_empty;

    assign off_eff = eff_offset(cfg_offset);
    assign wid_eff = eff_width(cfg_width);
    assign fifo_wr = '{left: tx_left, right: tx_right};

    i2s_slot_timer #(.STAGES(SYNC_STAGES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .bclk_in   (bclk_in),
        .wclk_in   (wclk_in),
        .sdata_in  (sdata_in),
        .wclk_s    (wclk_s),
        .bclk_fall (bclk_fall),
        .evt       (evt),
        .cnt       (cnt),
        .slot_len  (slot_len)
    );

    i2s_sample_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (tx_push),
        .wr_data (fifo_wr),
        .pop     (fifo_pop),
        .rd_data (fifo_rd),
        .full    (tx_full),
        .empty   (fifo_empty)
    );

    i2s_tx_ser u_tx (
        .clk        (clk),
        .rst        (rst),
        .bclk_fall  (bclk_fall),
        .evt        (evt),
        .cnt        (cnt),
        .slot_len   (slot_len),
        .off        (off_eff),
        .wid        (wid_eff),
        .stereo     (cfg_stereo),
        .fifo_empty (fifo_empty),
        .fifo_rd    (fifo_rd),
        .fifo_pop   (fifo_pop),
        .sd_out     (sdata_out),
        .underflow  (tx_underflow)
    );

    i2s_rx_deser u_rx (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .off      (off_eff),
        .wid      (wid_eff),
        .rx_valid (rx_valid),
        .rx_data  (rx_data)
    );
endmodule

// File: rtl/i2s_slave_port_chk.sv
module i2s_slave_port_chk (
    input logic clk,
    input logic rst,
    input logic bclk_fall,
    input logic sdata_out,
    input logic slot_start,
    input logic tx_full,
    input logic fifo_empty,
    input logic tx_underflow,
    input logic rx_valid,
    input logic wclk_s
);
    // R2
    tx_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdata_out) |-> $past(bclk_fall));

    // R5
    slot_head_chk: assert property (@(posedge clk) disable iff (rst)
        slot_start |-> !sdata_out);

    // R7
    full_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        tx_full |-> !fifo_empty);

    // R8
    udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        tx_underflow |=> tx_underflow);

    // R8
    udf_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_underflow) |-> ($past(slot_start) && $past(fifo_empty) && !$past(wclk_s)));

    // R9
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R9
    rx_slot_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> wclk_s);
endmodule

bind i2s_slave_port i2s_slave_port_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bclk_fall    (bclk_fall),
    .sdata_out    (sdata_out),
    .slot_start   (evt.start),
    .tx_full      (tx_full),
    .fifo_empty   (fifo_empty),
    .tx_underflow (tx_underflow),
    .rx_valid     (rx_valid),
    .wclk_s       (wclk_s)
);

// File: tb/i2s_slave_port_tb.sv
module i2s_slave_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int SLOT       = 32;
    localparam int WATCHDOG   = 150000;
    localparam int NVEC       = 10;

    typedef struct packed {
        logic [4:0]  off;
        logic [4:0]  wid;
        logic        st;
        logic [15:0] l;
        logic [15:0] r;
        logic [15:0] mic;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{5'd1,  5'd0,  1'b1, 16'hA5C3, 16'h1234, 16'hBEEF},
        '{5'd1,  5'd16, 1'b1, 16'h8001, 16'h7FFE, 16'h0F0F},
        '{5'd1,  5'd31, 1'b1, 16'hC3A5, 16'h5A5A, 16'hF00D},
        '{5'd1,  5'd8,  1'b1, 16'hFFFF, 16'h00FF, 16'hFFFF},
        '{5'd3,  5'd12, 1'b1, 16'h9249, 16'h6DB6, 16'hACE1},
        '{5'd0,  5'd16, 1'b1, 16'hF0F0, 16'h0F0F, 16'h1357},
        '{5'd20, 5'd16, 1'b1, 16'hDEAD, 16'hBEEF, 16'hCAFE},
        '{5'd1,  5'd16, 1'b0, 16'h4321, 16'hFFFF, 16'h2468},
        '{5'd31, 5'd1,  1'b1, 16'h8000, 16'h8000, 16'h8000},
        '{5'd5,  5'd0,  1'b0, 16'h7E7E, 16'h0000, 16'h9999}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bclk = 1'b0, wclk = 1'b0, sdin = 1'b0;
    logic [4:0] cfg_offset = 5'd1, cfg_width = 5'd0;
    logic cfg_stereo = 1'b1;
    logic tx_push = 1'b0;
    logic [15:0] tx_left = '0, tx_right = '0;
    logic sdata_out, tx_full, tx_underflow, rx_valid;
    logic [15:0] rx_data;

    int tests = 0, fails = 0, rx_cnt = 0;
    logic [15:0] rx_last = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2s_slave_port u_dut (
        .clk(clk), .rst(rst), .bclk_in(bclk), .wclk_in(wclk), .sdata_in(sdin),
        .sdata_out(sdata_out), .cfg_offset(cfg_offset), .cfg_width(cfg_width),
        .cfg_stereo(cfg_stereo), .tx_push(tx_push), .tx_left(tx_left),
        .tx_right(tx_right), .tx_full(tx_full), .tx_underflow(tx_underflow),
        .rx_valid(rx_valid), .rx_data(rx_data)
    );

    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            rx_cnt++;
            rx_last = rx_data;
        end
    end

    function automatic int eo(int f); return (f == 0) ? 1 : f; endfunction
    function automatic int ew(int f); return (f == 0 || f >= 16) ? 16 : f; endfunction

    function automatic logic in_win(int off, int wid, int j);
        return (j >= eo(off)) && (j < eo(off) + ew(wid));
    endfunction

    function automatic logic [31:0] exp_slot(logic [15:0] w, int off, int wid);
        logic [31:0] v = '0;
        for (int j = 0; j < SLOT; j++)
            if (in_win(off, wid, j)) v[31-j] = w[15-(j-eo(off))];
        return v;
    endfunction

    function automatic logic [15:0] exp_rx(logic [15:0] m, int off, int wid);
        logic [15:0] v = '0;
        for (int k = 0; k < ew(wid); k++)
            if (eo(off) + k < SLOT) v[15-k] = m[15-k];
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bit_cycle(input logic ws, input logic din, output logic obs);
        bclk = 1'b0; wclk = ws; sdin = din;
        repeat (HALF) @(negedge clk);
        obs = sdata_out;
        bclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic run_frame(input logic [15:0] mic, input int off, input int wid,
                             output logic [31:0] lo, output logic [31:0] ro);
        logic o, d;
        for (int j = 0; j < SLOT; j++) begin
            d = in_win(off, wid, j) ? mic[15-(j-eo(off))] : 1'b1;
            bit_cycle(1'b0, d, o);
            lo[31-j] = o;
        end
        for (int j = 0; j < SLOT; j++) begin
            d = in_win(off, wid, j) ? ~mic[15-(j-eo(off))] : 1'b1;
            bit_cycle(1'b1, d, o);
            ro[31-j] = o;
        end
    endtask

    task automatic push_pair(input logic [15:0] l, input logic [15:0] r);
        tx_push = 1'b1; tx_left = l; tx_right = r;
        @(negedge clk);
        tx_push = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] lo, ro;
        int rc;
        repeat (5) @(negedge clk);
        // R1: reset state while reset is held
        chk("R1 sdata_out in reset", 32'(sdata_out), 0);
        chk("R1 rx_valid in reset", 32'(rx_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 tx_underflow after reset", 32'(tx_underflow), 0);
        chk("R1 tx_full after reset", 32'(tx_full), 0);

        // priming frame: no left-slot start seen yet, so no pop and no output word
        run_frame(16'h0000, 1, 0, lo, ro);
        chk("R8 no underflow before first frame", 32'(tx_underflow), 0);
        chk("R9 no word before a full left slot", 32'(rx_cnt), 0);

        // vector table walk
        for (int v = 0; v < NVEC; v++) begin
            cfg_offset = VECS[v].off;
            cfg_width  = VECS[v].wid;
            cfg_stereo = VECS[v].st;
            push_pair(VECS[v].l, VECS[v].r);
            rc = rx_cnt;
            run_frame(VECS[v].mic, int'(VECS[v].off), int'(VECS[v].wid), lo, ro);
            chk("R2 R3 R4 R5 R6 left slot bits", lo,
                exp_slot(VECS[v].l, int'(VECS[v].off), int'(VECS[v].wid)));
            chk("R2 R3 R4 R5 R6 right slot bits", ro,
                exp_slot(VECS[v].st ? VECS[v].r : VECS[v].l,
                         int'(VECS[v].off), int'(VECS[v].wid)));
            chk("R9 one word per frame", 32'(rx_cnt - rc), 1);
            chk("R3 R9 received word", 32'(rx_last),
                32'(exp_rx(VECS[v].mic, int'(VECS[v].off), int'(VECS[v].wid))));
        end
        chk("R8 no underflow while fed", 32'(tx_underflow), 0);

        // underflow: frame with empty FIFO
        cfg_offset = 5'd1; cfg_width = 5'd0; cfg_stereo = 1'b1;
        run_frame(16'h5555, 1, 0, lo, ro);
        chk("R8 zero left slot on underflow", lo, 0);
        chk("R8 zero right slot on underflow", ro, 0);
        chk("R8 underflow flag set", 32'(tx_underflow), 1);
        push_pair(16'h1111, 16'h2222);
        run_frame(16'h5555, 1, 0, lo, ro);
        chk("R8 data resumes after underflow", lo, exp_slot(16'h1111, 1, 0));
        chk("R8 underflow flag sticky", 32'(tx_underflow), 1);

        // FIFO fill, overflow push, ordered drain
        for (int i = 0; i < 4; i++) push_pair(16'h1000 + 16'(i), 16'h2000 + 16'(i));
        chk("R7 full after four pushes", 32'(tx_full), 1);
        push_pair(16'hBBBB, 16'hCCCC);
        chk("R7 still full after dropped push", 32'(tx_full), 1);
        for (int i = 0; i < 4; i++) begin
            run_frame(16'h0000, 1, 0, lo, ro);
            chk("R7 pairs drained in order", lo, exp_slot(16'h1000 + 16'(i), 1, 0));
            if (i == 0) chk("R7 not full after one pop", 32'(tx_full), 0);
        end
        run_frame(16'h0000, 1, 0, lo, ro);
        chk("R7 push while full was dropped", lo, 0);

        done = 1;
        finish_run();
    end
endmodule